// File: doc/BRIEF.md
# Cache-Line Burst Write Sequencer

This block drives the master side of a long memory write on a shared bus. It gets a start word address, a length in 32-bit words, a cache line size and a maximum burst length. It cuts the transfer into bus tenures. Each tenure gets a planned command, address and length. Wherever whole cache lines can be written from an aligned address, it uses the write-and-invalidate command. Elsewhere it uses an ordinary memory write. After every tenure the next burst is planned again from the current address and the words still owed.

A tenure ends for one of three reasons: the planned length runs out, the latency timer expires, or the target asserts stop. A write-and-invalidate burst does not stop at once when the latency timer expires. It keeps going up to the next cache-line boundary. After any early end, the block drops its request for at least one cycle and then requests the bus again. The rest of the transfer is sent in later tenures. The configuration inputs must stay stable while a transfer is running. Addresses and lengths count 32-bit words.

Top module: `wr_burst_seq`

## Requirements
- R1: With write-and-invalidate enabled, an aligned address and at least one cache line left, the burst uses `cmd_wrinv`=1. Its length is the largest multiple of the line size that is no larger than either the words left or the effective maximum burst.
- R2: With write-and-invalidate enabled and an address that is not on a line boundary, the burst is an ordinary write (`cmd_wrinv`=0). Its length is the smaller of the words left and the distance to the next boundary.
- R3: When fewer words than one line are left at an aligned address, or when write-and-invalidate is disabled, the burst is an ordinary write of the smaller of the words left and the effective maximum burst.
- R4: The effective maximum burst is `max_burst` rounded down to a power of two, or 1 when `max_burst` is zero. Write-and-invalidate is disabled when `cls_words` is zero, is not a power of two, or is larger than the effective maximum burst.
- R5: When the latency timer is (or has been) high during a write-and-invalidate tenure, the tenure continues. It ends on the first accepted word that leaves the address on a line boundary.
- R6: When the latency timer is (or has been) high during an ordinary write tenure, the tenure ends on the next accepted word.
- R7: When `tgt_stop` is high, `frame` ends after that cycle, and a word accepted in the same cycle counts. Stop has priority over latency and over the planned length. After a retry (stop with no word accepted in the tenure), the next tenure issues the same command at the same address.
- R8: After a disconnect (stop after some words), the next tenure is planned from the current address. Write-and-invalidate is used only if that address is on a line boundary.
- R9: `req` is high from the planned request until the end of `frame`. It is low in the cycle after `frame` falls, and it rises only after a cycle without `frame`.
- R10: `done` is a one-cycle pulse given once, after the last word has been sent. A start with zero length gives the pulse with no request.
- R11: `start` is ignored while `busy` is high. The transfer in progress keeps its address and count.
- R12: `cmd_wrinv`, `burst_addr` and `burst_len` hold steady for the whole of a tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_addr | input | ADDR_W | First word address |
| start_len | input | CNT_W | Number of words to write |
| cls_words | input | CFG_W | Cache line size in words |
| max_burst | input | CFG_W | Maximum burst length in words |
| gnt | input | 1 | Bus granted |
| lat_expired | input | 1 | Latency timer expired |
| tgt_ack | input | 1 | Target accepts a word this cycle |
| tgt_stop | input | 1 | Target asks to end the tenure |
| req | output | 1 | Bus request |
| frame | output | 1 | Tenure in progress |
| cmd_wrinv | output | 1 | 1 = write-and-invalidate, 0 = ordinary memory write |
| burst_addr | output | ADDR_W | Start address of the current burst |
| burst_len | output | CFG_W | Planned length of the current burst |
| busy | output | 1 | Transfer active |
| done | output | 1 | Transfer complete pulse |

## Verification
The latency expiry and the target stop can land on the same beat. Either of them can also coincide with the beat that reaches a line boundary or uses up the planned length. Directed cases force the latency timer and stop into one cycle, and the latency timer onto a boundary beat. Random runs at a few percent each keep producing further collisions. The bench model judges each one by ending the tenure after that cycle, with stop taking priority, and it predicts the command of the resumed tenure from the address that results.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PLAN,
      ST_REQ,
      ST_XFER,
      ST_REL
   } wbs_state_e;

   typedef enum logic {
      CMD_MEMWR = 1'b0,
      CMD_WRINV = 1'b1
   } wbs_cmd_e;

endpackage

// File: rtl/wbs_cfg_check.sv
module wbs_cfg_check #(
   parameter int CFG_W = 8
) (
   input  logic [CFG_W-1:0] cls_words,
   input  logic [CFG_W-1:0] max_burst,
   output logic             wi_en,
   output logic [CFG_W-1:0] maxb_eff
);

   if (CFG_W < 2) begin : g_bad_cfg
      $error("wbs_cfg_check: CFG_W must be at least 2");
   end

   logic [CFG_W-1:0] msb_oh;
   logic             cls_pow2;

   // one-hot of the highest set bit: rounds the maximum burst down to 2^k
   for (genvar i = 0; i < CFG_W; i++) begin : g_msb
      if (i == CFG_W-1) begin : g_top
         assign msb_oh[i] = max_burst[i];
      end else begin : g_low
         assign msb_oh[i] = max_burst[i] & ~(|max_burst[CFG_W-1:i+1]);
      end
   end

   always_comb begin
      maxb_eff = (max_burst == '0) ? CFG_W'(1) : msb_oh;
      cls_pow2 = (cls_words != '0) && ((cls_words & (cls_words - CFG_W'(1))) == '0);
      wi_en    = cls_pow2 && (cls_words <= maxb_eff);
   end

endmodule

// File: rtl/wbs_planner.sv
module wbs_planner #(
   parameter int CNT_W = 16,
   parameter int CFG_W = 8
) (
   input  logic [CFG_W-1:0] addr_lo,
   input  logic [CNT_W-1:0] rem,
   input  logic [CFG_W-1:0] cls_words,
   input  logic [CFG_W-1:0] maxb_eff,
   input  logic             wi_en,
   output logic             p_wrinv,
   output logic [CFG_W-1:0] p_len
);

   if (CNT_W < CFG_W) begin : g_bad_cnt
      $error("wbs_planner: CNT_W must not be narrower than CFG_W");
   end

   logic [CFG_W-1:0] cls_mask;
   logic [CFG_W-1:0] offset;
   logic [CFG_W-1:0] to_bnd;
   logic [CNT_W-1:0] whole_lines;
   logic [CNT_W-1:0] maxb_x;
   logic [CNT_W-1:0] cls_x;
   logic [CNT_W-1:0] bnd_x;
   logic [CNT_W-1:0] len_x;

   always_comb begin
      cls_mask    = cls_words - CFG_W'(1);
      offset      = addr_lo & cls_mask;
      to_bnd      = cls_words - offset;
      maxb_x      = CNT_W'(maxb_eff);
      cls_x       = CNT_W'(cls_words);
      bnd_x       = CNT_W'(to_bnd);
      whole_lines = rem & ~CNT_W'(cls_mask);
      p_wrinv     = 1'b0;
      if (wi_en && (offset == '0) && (rem >= cls_x)) begin
         p_wrinv = 1'b1;
         len_x   = (whole_lines < maxb_x) ? whole_lines : maxb_x;
      end else if (wi_en && (offset != '0)) begin
         len_x   = (rem < bnd_x) ? rem : bnd_x;
      end else begin
         len_x   = (rem < maxb_x) ? rem : maxb_x;
      end
      p_len = len_x[CFG_W-1:0];
   end

endmodule

// File: rtl/wbs_tenure_ctl.sv
module wbs_tenure_ctl
   import wbs_pkg::*;
#(
   parameter int ADDR_W = 30,
   parameter int CNT_W  = 16,
   parameter int CFG_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  start_len,
   input  logic [CFG_W-1:0]  cls_words,
   input  logic              p_wrinv,
   input  logic [CFG_W-1:0]  p_len,
   input  logic              gnt,
   input  logic              lat_expired,
   input  logic              tgt_ack,
   input  logic              tgt_stop,
   output logic              req,
   output logic              frame,
   output logic              cmd_wrinv,
   output logic [ADDR_W-1:0] burst_addr,
   output logic [CFG_W-1:0]  burst_len,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_rem
);

   wbs_state_e        state;
   wbs_cmd_e          cmd;
   logic [CFG_W-1:0]  cnt;
   logic              lat_seen;

   logic              beat;
   logic [ADDR_W-1:0] nxt_addr;
   logic [CFG_W-1:0]  nxt_cnt;
   logic              lat_now;
   logic              at_bnd;
   logic              end_now;
   logic [CFG_W-1:0]  cls_mask;

   always_comb begin
      cls_mask = cls_words - CFG_W'(1);
      beat     = (state == ST_XFER) && tgt_ack;
      nxt_addr = cur_addr + ADDR_W'(beat);
      nxt_cnt  = cnt - CFG_W'(beat);
      lat_now  = lat_seen | lat_expired;
      at_bnd   = (nxt_addr[CFG_W-1:0] & cls_mask) == '0;
      end_now  = tgt_stop |
                 (beat & ((nxt_cnt == '0) |
                          (lat_now & ((cmd == CMD_MEMWR) | at_bnd))));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cmd        <= CMD_MEMWR;
         cnt        <= '0;
         lat_seen   <= 1'b0;
         cur_addr   <= '0;
         cur_rem    <= '0;
         burst_addr <= '0;
         burst_len  <= '0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  cur_addr <= start_addr;
                  cur_rem  <= start_len;
                  if (start_len == '0) done  <= 1'b1;
                  else                 state <= ST_PLAN;
               end
            end
            ST_PLAN: begin
               cmd        <= p_wrinv ? CMD_WRINV : CMD_MEMWR;
               burst_addr <= cur_addr;
               burst_len  <= p_len;
               cnt        <= p_len;
               lat_seen   <= 1'b0;
               state      <= ST_REQ;
            end
            ST_REQ: begin
               if (gnt) state <= ST_XFER;
            end
            ST_XFER: begin
               cur_addr <= nxt_addr;
               cur_rem  <= cur_rem - CNT_W'(beat);
               cnt      <= nxt_cnt;
               lat_seen <= lat_now;
               if (end_now) state <= ST_REL;
            end
            ST_REL: begin
               if (cur_rem == '0) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  state <= ST_PLAN;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req       = (state == ST_REQ) || (state == ST_XFER);
      frame     = (state == ST_XFER);
      busy      = (state != ST_IDLE);
      cmd_wrinv = (cmd == CMD_WRINV);
   end

   // ---------------- assertions ----------------
   assert_release_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame) |-> !req);

   assert_req_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $past(!frame));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_no_overrun_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frame |-> (cnt != '0));

   assert_plan_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PLAN && p_wrinv) |-> ((p_len & cls_mask) == '0) && (p_len != '0));

   assert_lat_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(frame) && $past(cmd_wrinv) && !$past(tgt_stop) && $past(lat_now))
      |-> ((cur_addr[CFG_W-1:0] & cls_mask) == '0));

   assert_tenure_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (frame && $past(frame)) |->
      ($stable(burst_addr) && $stable(burst_len) && $stable(cmd_wrinv)));

   assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state != ST_XFER) |=> ($stable(cur_rem) && $stable(cur_addr)));

endmodule

// File: rtl/wr_burst_seq.sv
module wr_burst_seq
   import wbs_pkg::*;
#(
   parameter int ADDR_W = 30,
   parameter int CNT_W  = 16,
   parameter int CFG_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  start_len,
   input  logic [CFG_W-1:0]  cls_words,
   input  logic [CFG_W-1:0]  max_burst,
   input  logic              gnt,
   input  logic              lat_expired,
   input  logic              tgt_ack,
   input  logic              tgt_stop,
   output logic              req,
   output logic              frame,
   output logic              cmd_wrinv,
   output logic [ADDR_W-1:0] burst_addr,
   output logic [CFG_W-1:0]  burst_len,
   output logic              busy,
   output logic              done
);

   if (ADDR_W < CFG_W) begin : g_bad_addr
      $error("wr_burst_seq: ADDR_W must not be narrower than CFG_W");
   end

   logic              wi_en;
   logic [CFG_W-1:0]  maxb_eff;
   logic              p_wrinv;
   logic [CFG_W-1:0]  p_len;
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  cur_rem;

   wbs_cfg_check #(.CFG_W(CFG_W)) u_cfg (
      .cls_words (cls_words),
      .max_burst (max_burst),
      .wi_en     (wi_en),
      .maxb_eff  (maxb_eff)
   );

   wbs_planner #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_plan (
      .addr_lo   (cur_addr[CFG_W-1:0]),
      .rem       (cur_rem),
      .cls_words (cls_words),
      .maxb_eff  (maxb_eff),
      .wi_en     (wi_en),
      .p_wrinv   (p_wrinv),
      .p_len     (p_len)
   );

   wbs_tenure_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_addr  (start_addr),
      .start_len   (start_len),
      .cls_words   (cls_words),
      .p_wrinv     (p_wrinv),
      .p_len       (p_len),
      .gnt         (gnt),
      .lat_expired (lat_expired),
      .tgt_ack     (tgt_ack),
      .tgt_stop    (tgt_stop),
      .req         (req),
      .frame       (frame),
      .cmd_wrinv   (cmd_wrinv),
      .burst_addr  (burst_addr),
      .burst_len   (burst_len),
      .busy        (busy),
      .done        (done),
      .cur_addr    (cur_addr),
      .cur_rem     (cur_rem)
   );

endmodule

// File: tb/tb_wr_burst_seq.sv
module tb_wr_burst_seq;
   localparam int ADDR_W = 30;
   localparam int CNT_W  = 16;
   localparam int CFG_W  = 8;
   localparam int LIMIT  = 190000;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n, start, gnt, lat_expired, tgt_ack, tgt_stop;
   logic [ADDR_W-1:0] start_addr;
   logic [CNT_W-1:0]  start_len;
   logic [CFG_W-1:0]  cls_words, max_burst;
   logic              req, frame, cmd_wrinv, busy, done;
   logic [ADDR_W-1:0] burst_addr;
   logic [CFG_W-1:0]  burst_len;

   wr_burst_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .start_len(start_len), .cls_words(cls_words), .max_burst(max_burst),
      .gnt(gnt), .lat_expired(lat_expired), .tgt_ack(tgt_ack), .tgt_stop(tgt_stop),
      .req(req), .frame(frame), .cmd_wrinv(cmd_wrinv), .burst_addr(burst_addr),
      .burst_len(burst_len), .busy(busy), .done(done)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;

   // model state
   longint m_addr, m_rem;
   int  cls_v, mb_v, m_cnt, ten_cyc, words, done_seen;
   bit  m_wi, m_lat, in_ten, exp_frame;
   bit  prev_retry, prev_disc, prev_cmd;
   string end_tag;
   int  ack_pct, stop_pct, lat_pct;
   int  dir_lat_at = -1, dir_stop_at = -1;
   bit  dir_stop_ack;
   bit  pend_start;
   logic [ADDR_W-1:0] p_addr;
   logic [CNT_W-1:0]  p_len;
   logic              cap_cmd;
   logic [ADDR_W-1:0] cap_addr;
   logic [CFG_W-1:0]  cap_len;

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic int eff_max(input int mb);
      int e = 1;
      if (mb == 0) return 1;
      for (int b = 0; b < CFG_W; b++) if ((mb >> b) & 1) e = 1 << b;
      return e;
   endfunction

   function automatic bit line_ok(input int cls, input int mb);
      return (cls != 0) && ((cls & (cls - 1)) == 0) && (cls <= eff_max(mb));
   endfunction

   function automatic void exp_plan(input longint addr, input longint rem,
                                    input int cls, input int mb,
                                    output bit wi, output int len, output string tg);
      int mbe = eff_max(mb);
      longint off;
      wi = 0;
      if (!line_ok(cls, mb)) begin
         len = (rem < mbe) ? int'(rem) : mbe; tg = "R4";
         return;
      end
      off = addr % cls;
      if (off == 0 && rem >= cls) begin
         longint lines = (rem / cls) * cls;
         wi = 1; len = (lines < mbe) ? int'(lines) : mbe; tg = "R1";
      end else if (off != 0) begin
         len = (rem < cls - off) ? int'(rem) : int'(cls - off); tg = "R2";
      end else begin
         len = (rem < mbe) ? int'(rem) : mbe; tg = "R3";
      end
   endfunction

   task automatic step();
      bit a, s, l, wi, aligned, fin;
      int len;
      string tg;
      @(negedge clk);
      cyc++;
      if (done) begin
         done_seen++;
         check(m_rem == 0, "R10", "done with words left", m_rem, 0);
      end
      if (in_ten) begin
         check(frame == exp_frame, end_tag, "tenure end timing", frame, exp_frame);
         if (!exp_frame) begin
            in_ten = 0;
            check(req == 1'b0, "R9", "req in release cycle", req, 0);
         end
      end
      if (frame && !in_ten) begin
         exp_plan(m_addr, m_rem, cls_v, mb_v, wi, len, tg);
         if (prev_disc) tg = "R8";
         check(cmd_wrinv == wi, tg, "burst command", cmd_wrinv, wi);
         check(burst_len == len, tg, "burst length", burst_len, len);
         check(burst_addr == m_addr[ADDR_W-1:0], tg, "burst address", burst_addr, m_addr);
         if (prev_retry)
            check(cmd_wrinv == prev_cmd, "R7", "command after retry", cmd_wrinv, prev_cmd);
         in_ten = 1; m_wi = wi; m_cnt = len; m_lat = 0; ten_cyc = 0; words = 0;
         cap_cmd = cmd_wrinv; cap_addr = burst_addr; cap_len = burst_len;
      end else if (frame) begin
         check(cmd_wrinv == cap_cmd && burst_addr == cap_addr && burst_len == cap_len,
               "R12", "tenure fields held", burst_len, cap_len);
      end
      // drive inputs for the next edge
      start = pend_start;
      if (pend_start) begin start_addr = p_addr; start_len = p_len; end
      pend_start = 0;
      gnt = req && ($urandom_range(0, 3) != 0);
      if (frame) begin
         a = ($urandom_range(0, 99) < ack_pct);
         s = ($urandom_range(0, 99) < stop_pct);
         l = ($urandom_range(0, 99) < lat_pct);
         if (ten_cyc == dir_lat_at) l = 1;
         if (ten_cyc == dir_stop_at) begin s = 1; a = dir_stop_ack; end
         if (ten_cyc == 0 && dir_stop_at < 0 && dir_lat_at >= 0) a = 1;
         tgt_ack = a; tgt_stop = s; lat_expired = l;
         if (a) begin m_addr++; m_rem--; m_cnt--; words++; end
         m_lat = m_lat | l;
         aligned = m_wi ? ((m_addr % cls_v) == 0) : 1'b0;
         fin = s || (a && (m_cnt == 0 || (m_lat && (!m_wi || aligned))));
         if (s) end_tag = "R7";
         else if (m_lat) end_tag = m_wi ? "R5" : "R6";
         else end_tag = "R1";
         exp_frame = !fin;
         if (fin) begin
            prev_retry = s && (words == 0);
            prev_disc  = s && (words != 0);
            prev_cmd   = m_wi;
            dir_lat_at = -1; dir_stop_at = -1;
         end
         ten_cyc++;
      end else begin
         tgt_ack = 0; tgt_stop = 0; lat_expired = 0;
      end
   endtask

   task automatic run_xfer(input int addr, input int len, input int cls, input int mb,
                           input int ap, input int sp, input int lp, input bit inject);
      int k = 0;
      cls_words = CFG_W'(cls); max_burst = CFG_W'(mb);
      cls_v = cls; mb_v = mb;
      ack_pct = ap; stop_pct = sp; lat_pct = lp;
      p_addr = ADDR_W'(addr); p_len = CNT_W'(len); pend_start = 1;
      m_addr = addr; m_rem = len; done_seen = 0;
      prev_retry = 0; prev_disc = 0; in_ten = 0;
      while (done_seen == 0 && k < 20000) begin
         if (inject && k == 6) begin
            // R11: a second start while busy must change nothing
            p_addr = ADDR_W'(addr + 13); p_len = CNT_W'(3); pend_start = 1;
         end
         step();
         k++;
      end
      check(done_seen == 1, "R10", "done pulse seen", done_seen, 1);
      repeat (3) step();
      check(done_seen == 1, "R10", "single done pulse", done_seen, 1);
      check(busy == 1'b0 && req == 1'b0, inject ? "R11" : "R10", "idle after done", busy, 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         if (cyc > LIMIT) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, LIMIT);
            summary();
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; start = 0; gnt = 0; lat_expired = 0; tgt_ack = 0; tgt_stop = 0;
      start_addr = '0; start_len = '0; cls_words = 8'd4; max_burst = 8'd16;
      repeat (3) @(negedge clk);
      check(req == 0 && frame == 0, "R9", "reset: no request", req, 0);
      check(done == 0 && busy == 0, "R10", "reset: idle", done, 0);
      rst_n = 1;
      // R1 shrinking bursts: 16,16,12 of write-and-invalidate then 1 word ordinary
      run_xfer(0, 45, 4, 16, 100, 0, 0, 0);
      // R2 unaligned start: 5-word ordinary write to the boundary first
      run_xfer(3, 40, 8, 32, 100, 0, 0, 0);
      // R4 disabled cases: zero line, line above max, max rounded down (12 -> 8)
      run_xfer(8, 30, 0, 16, 100, 0, 0, 0);
      run_xfer(0, 30, 32, 16, 100, 0, 0, 0);
      run_xfer(0, 30, 8, 12, 100, 0, 0, 0);
      run_xfer(5, 9, 4, 0, 100, 0, 0, 0);
      // R5 latency in the middle of a multi-line burst: stop at address 4
      dir_lat_at = 1;
      run_xfer(0, 32, 4, 16, 100, 0, 0, 0);
      // R5 latency exactly on a boundary beat
      dir_lat_at = 3;
      run_xfer(0, 32, 4, 16, 100, 0, 0, 0);
      // R6 latency during an ordinary write
      dir_lat_at = 2;
      run_xfer(0, 20, 0, 8, 100, 0, 0, 0);
      // R7 retry on the first cycle: same command again
      dir_stop_at = 0; dir_stop_ack = 0;
      run_xfer(0, 32, 4, 16, 100, 0, 0, 0);
      // R8 disconnect after three words: resume with an ordinary write
      dir_stop_at = 2; dir_stop_ack = 1;
      run_xfer(0, 32, 4, 16, 100, 0, 0, 0);
      // R7 stop and latency in the same cycle: stop wins
      dir_stop_at = 3; dir_stop_ack = 0; dir_lat_at = 3;
      run_xfer(0, 32, 8, 16, 100, 0, 0, 0);
      // R10 zero length
      run_xfer(7, 0, 4, 16, 100, 0, 0, 0);
      // R11 start while busy
      run_xfer(2, 90, 4, 16, 80, 0, 0, 1);
      // random mix
      for (int t = 0; t < 40; t++) begin
         int cls_tab[8] = '{0, 1, 2, 4, 8, 16, 32, 3};
         int mb_tab[7]  = '{1, 4, 8, 16, 32, 0, 12};
         run_xfer(int'($urandom_range(0, 511)), int'($urandom_range(1, 200)),
                  cls_tab[$urandom_range(0, 7)], mb_tab[$urandom_range(0, 6)],
                  int'($urandom_range(60, 100)), 3, 3, 0);
      end
      summary();
      $finish;
   end

endmodule